// File: doc/BRIEF.md
# MMU Access Exception Classifier

This block sits beside the load/store and fetch pipelines and decides, for each memory access it is handed, whether the access must trap and with which exception class. It looks the access address up in a small instruction translation buffer or a small data translation buffer. It also weighs the access kind against the segment direct-store flag, the page write-through and cache-inhibit attributes, the data-cache lock controls, the external-access enable and the little-endian mode flag.

At most one exception is reported per access. The result is registered and appears one clock after the request. It carries a cause code, the SRR1 and DSISR bits the handler would save, and a request to set the MSR bit that selects the shadow registers for the TLB-miss handlers. Walking page tables and refilling the buffers are left to software and other logic. The buffer images come in on ports.

Top module: `mmu_exc_classifier`

## Requirements
- R1: A request with `reqValid` high at a rising edge gives `excValid` high after that edge. A cycle with `reqValid` low gives `excValid` low, `excCause` 0 and all status outputs 0 after the edge. During reset all outputs are 0.
- R2: An access of kind 0 (fetch) that hits no ITLB entry gives cause 1, SRR1 bit 13 set and `setShadowMsr` high. The status vectors are declared `[0:31]`, so index n is architectural bit n. A fetch that hits gives cause 0.
- R3: A read data access that hits no DTLB entry gives cause 2, with SRR1 bit 13 clear, SRR1 bit 15 set and `setShadowMsr` high. Read accesses are kind 1 (load), and kinds 4, 5, 6 and 7 with `reqWrite` low.
- R4: A write data access gives cause 3, SRR1 all zero and `setShadowMsr` high when it hits no DTLB entry, or when the hit entry has C = 0. Write accesses are kind 2 (store), kind 3 (cache-block zero), and kinds 4, 5, 6 and 7 with `reqWrite` high. C = 0 has no effect on reads.
- R5: A kind 3 (cache-block zero) access that hits a DTLB entry with W = 1 or I = 1 gives cause 4 (alignment).
- R6: A kind 3 access while either bit of `cacheLock` is set gives cause 4.
- R7: A kind 4 (reservation) or kind 5 (external control) access with `segDirect` = 1 gives cause 5 (DSI) with DSISR bit 5 set and no other status bit. `segDirect` does not affect other kinds.
- R8: A kind 5 access with `extEnable` = 0 gives cause 5 with DSISR bit 11 set and no other status bit.
- R9: A kind 6 (load/store multiple or string) access with `littleEndian` = 1 gives cause 4. `littleEndian` does not affect other kinds.
- R10: When several conditions apply, the first of these is reported: little-endian multiple/string, segment DSI, external-enable DSI, cache-block-zero alignment, TLB or changed-bit miss.
- R11: Each buffer has 4 entries. Entry k takes bits [24k+23:24k] of its port: bit 23 valid, bits 22:3 tag, bit 2 W, bit 1 I, bit 0 C. An entry hits when it is valid and its tag equals `reqAddr[31:12]`. An invalid entry never hits.
- R12: An access that meets no exception condition gives cause 0, with SRR1, DSISR and `setShadowMsr` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request present this cycle |
| reqKind | input | 3 | Access kind code (see R2 to R9) |
| reqWrite | input | 1 | Write direction for kinds 4 to 7 |
| reqAddr | input | 32 | Effective address of the access |
| itlbImage | input | 96 | Four instruction buffer entries |
| dtlbImage | input | 96 | Four data buffer entries |
| segDirect | input | 1 | Segment direct-store flag |
| cacheLock | input | 2 | Data-cache lock controls |
| extEnable | input | 1 | External-access enable |
| littleEndian | input | 1 | Little-endian mode |
| excValid | output | 1 | Registered result valid |
| excCause | output | 3 | Cause: 0 none, 1 ITLB miss, 2 DTLB load miss, 3 DTLB store miss, 4 alignment, 5 DSI |
| srr1Bits | output | 32 | SRR1 bits, index n = architectural bit n |
| dsisrBits | output | 32 | DSISR bits, index n = architectural bit n |
| setShadowMsr | output | 1 | Request to set MSR bit 14 |

## Verification
The hardest situations to reach are those where several exception conditions are true at once, because only the priority order decides what is reported. Examples are an external-control access to a direct-store segment with the enable also off, or a cache-block zero on a locked cache to a write-through page. The bench keeps one fixed buffer image with pages that miss, pages that hit with C clear and pages with W or I set. It then stacks the mode inputs on those addresses in its vector table, so each rung of the priority chain is shown winning against the rungs below it.

// File: rtl/mmu_exc_pkg.sv
package mmu_exc_pkg;
  localparam int ADDR_W   = 32;
  localparam int PAGE_W   = 12;
  localparam int TAG_W    = ADDR_W - PAGE_W;
  localparam int ENTRY_W  = TAG_W + 4;
  localparam int ENTRIES  = 4;
  localparam int STAT_W   = 32;

  localparam int SRR1_ITLB_BIT  = 13;
  localparam int SRR1_LOAD_BIT  = 15;
  localparam int DSISR_SEG_BIT  = 5;
  localparam int DSISR_EXT_BIT  = 11;

  typedef enum logic [2:0] {
    ACC_FETCH = 3'd0,
    ACC_LOAD  = 3'd1,
    ACC_STORE = 3'd2,
    ACC_ZERO  = 3'd3,
    ACC_RSV   = 3'd4,
    ACC_EXT   = 3'd5,
    ACC_MULTI = 3'd6,
    ACC_FP    = 3'd7
  } accKind_e;

  typedef enum logic [2:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_ITLB   = 3'd1,
    CAUSE_DLOAD  = 3'd2,
    CAUSE_DSTORE = 3'd3,
    CAUSE_ALIGN  = 3'd4,
    CAUSE_DSI    = 3'd5
  } cause_e;

  typedef struct packed {
    logic hit;
    logic w;
    logic i;
    logic c;
  } tlbLook_t;

  typedef struct packed {
    logic   capture;
    cause_e cause;
    logic   dsiSeg;
    logic   dsiExt;
  } ctrlStrobe_t;
endpackage

// File: rtl/mmu_tlb_match.sv
module mmu_tlb_match
  import mmu_exc_pkg::*;
#(
  parameter int NUM_ENT = ENTRIES,
  parameter int TAG_BITS = TAG_W,
  localparam int ENT_W = TAG_BITS + 4
) (
  input  logic [NUM_ENT*ENT_W-1:0] image,
  input  logic [TAG_BITS-1:0]      lookupTag,
  output tlbLook_t                 look
);
  logic [NUM_ENT-1:0] entHit;

  for (genvar k = 0; k < NUM_ENT; k++) begin : g_ent
    logic [ENT_W-1:0] ent;
    assign ent = image[k*ENT_W +: ENT_W];
    assign entHit[k] = ent[ENT_W-1] && (ent[3 +: TAG_BITS] == lookupTag);
  end

  // lowest index wins on multiple hits
  always_comb begin
    look = '0;
    for (int k = NUM_ENT - 1; k >= 0; k--) begin
      if (entHit[k]) begin
        look.hit = 1'b1;
        look.w   = image[k*ENT_W + 2];
        look.i   = image[k*ENT_W + 1];
        look.c   = image[k*ENT_W];
      end
    end
  end
endmodule

// File: rtl/mmu_exc_ctrl.sv
module mmu_exc_ctrl
  import mmu_exc_pkg::*;
(
  input  logic        reqValid,
  input  logic [2:0]  reqKind,
  input  logic        reqWrite,
  input  logic        segDirect,
  input  logic [1:0]  cacheLock,
  input  logic        extEnable,
  input  logic        littleEndian,
  input  tlbLook_t    iLook,
  input  tlbLook_t    dLook,
  output ctrlStrobe_t strobe
);
  accKind_e kind;
  logic isWrite, leMulti, segHit, extOff, zeroAlign, dataMiss;

  assign kind = accKind_e'(reqKind);

  always_comb begin
    unique case (kind)
      ACC_STORE, ACC_ZERO: isWrite = 1'b1;
      ACC_RSV, ACC_EXT, ACC_MULTI, ACC_FP: isWrite = reqWrite;
      default: isWrite = 1'b0;
    endcase
  end

  assign leMulti   = (kind == ACC_MULTI) && littleEndian;
  assign segHit    = ((kind == ACC_RSV) || (kind == ACC_EXT)) && segDirect;
  assign extOff    = (kind == ACC_EXT) && !extEnable;
  assign zeroAlign = (kind == ACC_ZERO) &&
                     ((|cacheLock) || (dLook.hit && (dLook.w || dLook.i)));
  assign dataMiss  = !dLook.hit || (isWrite && !dLook.c);

  always_comb begin
    strobe = '0;
    strobe.capture = reqValid;
    strobe.cause   = CAUSE_NONE;
    if (reqValid) begin
      if (kind == ACC_FETCH) begin
        if (!iLook.hit) strobe.cause = CAUSE_ITLB;
      end else if (leMulti) begin
        strobe.cause = CAUSE_ALIGN;
      end else if (segHit) begin
        strobe.cause  = CAUSE_DSI;
        strobe.dsiSeg = 1'b1;
      end else if (extOff) begin
        strobe.cause  = CAUSE_DSI;
        strobe.dsiExt = 1'b1;
      end else if (zeroAlign) begin
        strobe.cause = CAUSE_ALIGN;
      end else if (dataMiss) begin
        strobe.cause = isWrite ? CAUSE_DSTORE : CAUSE_DLOAD;
      end
    end
  end
endmodule

// File: rtl/mmu_exc_datapath.sv
module mmu_exc_datapath
  import mmu_exc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [TAG_W-1:0]       pageTag,
  input  logic [ENTRIES*ENTRY_W-1:0] itlbImage,
  input  logic [ENTRIES*ENTRY_W-1:0] dtlbImage,
  input  ctrlStrobe_t            strobe,
  output tlbLook_t               iLook,
  output tlbLook_t               dLook,
  output logic                   excValid,
  output logic [2:0]             excCause,
  output logic [0:STAT_W-1]      srr1Bits,
  output logic [0:STAT_W-1]      dsisrBits,
  output logic                   setShadowMsr
);
  logic [0:STAT_W-1] srr1Next, dsisrNext;
  logic              msrNext;

  mmu_tlb_match #(.NUM_ENT(ENTRIES), .TAG_BITS(TAG_W)) u_itlb (
    .image(itlbImage), .lookupTag(pageTag), .look(iLook)
  );
  mmu_tlb_match #(.NUM_ENT(ENTRIES), .TAG_BITS(TAG_W)) u_dtlb (
    .image(dtlbImage), .lookupTag(pageTag), .look(dLook)
  );

  always_comb begin
    srr1Next  = '0;
    dsisrNext = '0;
    srr1Next[SRR1_ITLB_BIT]  = (strobe.cause == CAUSE_ITLB);
    srr1Next[SRR1_LOAD_BIT]  = (strobe.cause == CAUSE_DLOAD);
    dsisrNext[DSISR_SEG_BIT] = strobe.dsiSeg;
    dsisrNext[DSISR_EXT_BIT] = strobe.dsiExt;
    msrNext = (strobe.cause == CAUSE_ITLB) || (strobe.cause == CAUSE_DLOAD) ||
              (strobe.cause == CAUSE_DSTORE);
  end

  always_ff @(posedge clk) begin
    if (!rstN || !strobe.capture) begin
      excValid     <= 1'b0;
      excCause     <= CAUSE_NONE;
      srr1Bits     <= '0;
      dsisrBits    <= '0;
      setShadowMsr <= 1'b0;
    end else begin
      excValid     <= 1'b1;
      excCause     <= strobe.cause;
      srr1Bits     <= srr1Next;
      dsisrBits    <= dsisrNext;
      setShadowMsr <= msrNext;
    end
  end
endmodule

// File: rtl/mmu_exc_classifier.sv
module mmu_exc_classifier
  import mmu_exc_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic [2:0]                 reqKind,
  input  logic                       reqWrite,
  input  logic [ADDR_W-1:0]          reqAddr,
  input  logic [ENTRIES*ENTRY_W-1:0] itlbImage,
  input  logic [ENTRIES*ENTRY_W-1:0] dtlbImage,
  input  logic                       segDirect,
  input  logic [1:0]                 cacheLock,
  input  logic                       extEnable,
  input  logic                       littleEndian,
  output logic                       excValid,
  output logic [2:0]                 excCause,
  output logic [0:STAT_W-1]          srr1Bits,
  output logic [0:STAT_W-1]          dsisrBits,
  output logic                       setShadowMsr
);
  tlbLook_t    iLook, dLook;
  ctrlStrobe_t strobe;

  mmu_exc_ctrl u_ctrl (
    .reqValid(reqValid), .reqKind(reqKind), .reqWrite(reqWrite),
    .segDirect(segDirect), .cacheLock(cacheLock), .extEnable(extEnable),
    .littleEndian(littleEndian), .iLook(iLook), .dLook(dLook),
    .strobe(strobe)
  );

  mmu_exc_datapath u_dp (
    .clk(clk), .rstN(rstN), .pageTag(reqAddr[ADDR_W-1:PAGE_W]),
    .itlbImage(itlbImage), .dtlbImage(dtlbImage), .strobe(strobe),
    .iLook(iLook), .dLook(dLook), .excValid(excValid),
    .excCause(excCause), .srr1Bits(srr1Bits), .dsisrBits(dsisrBits),
    .setShadowMsr(setShadowMsr)
  );
endmodule

// File: rtl/mmu_exc_checker.sv
module mmu_exc_checker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [2:0]  reqKind,
  input logic        segDirect,
  input logic        littleEndian,
  input logic        excValid,
  input logic [2:0]  excCause,
  input logic [0:31] srr1Bits,
  input logic [0:31] dsisrBits,
  input logic        setShadowMsr
);
  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> excValid);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!excValid && excCause == 3'd0 && srr1Bits == '0 &&
                   dsisrBits == '0 && !setShadowMsr));

  p_itlb_bits_r2: assert property (@(posedge clk) disable iff (!rstN)
    excCause == 3'd1 |-> (srr1Bits[13] && !srr1Bits[15] && setShadowMsr));

  p_dload_bits_r3: assert property (@(posedge clk) disable iff (!rstN)
    excCause == 3'd2 |-> (!srr1Bits[13] && srr1Bits[15] && setShadowMsr));

  p_dstore_bits_r4: assert property (@(posedge clk) disable iff (!rstN)
    excCause == 3'd3 |-> (srr1Bits == '0 && dsisrBits == '0 && setShadowMsr));

  // R7 / R8: a DSI carries exactly one DSISR bit and no MSR request
  p_dsi_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    excCause == 3'd5 |-> ($countones(dsisrBits) == 1 && srr1Bits == '0 &&
                          !setShadowMsr));

  p_seg_dsi_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (reqKind == 3'd4 || reqKind == 3'd5) && segDirect)
      |=> (excCause == 3'd5 && dsisrBits[5]));

  p_le_multi_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == 3'd6 && littleEndian) |=> excCause == 3'd4);

  p_none_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    excCause == 3'd0 |-> (srr1Bits == '0 && dsisrBits == '0 && !setShadowMsr));
endmodule

bind mmu_exc_classifier mmu_exc_checker u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
  .segDirect(segDirect), .littleEndian(littleEndian), .excValid(excValid),
  .excCause(excCause), .srr1Bits(srr1Bits), .dsisrBits(dsisrBits),
  .setShadowMsr(setShadowMsr)
);

// File: tb/sim_mmu_exc_classifier.sv
module sim_mmu_exc_classifier;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 27;

  typedef struct packed {
    logic [31:0] tag;
    logic [2:0]  kind;
    logic        wr;
    logic [31:0] addr;
    logic        seg;
    logic [1:0]  lock;
    logic        extEn;
    logic        le;
    logic [2:0]  cause;
    logic [4:0]  dsiBit;
  } vec_t;

  // fields: tag, kind, wr, addr, seg, lock, extEn, le, cause, dsiBit(0=none)
  localparam vec_t VEC [NV] = '{
    '{"R2  ", 3'd0, 1'b0, 32'h0001_0ABC, 1'b0, 2'd0, 1'b1, 1'b0, 3'd0, 5'd0},
    '{"R11 ", 3'd0, 1'b0, 32'h0002_0000, 1'b0, 2'd0, 1'b1, 1'b0, 3'd1, 5'd0},
    '{"R2  ", 3'd0, 1'b0, 32'h0009_9000, 1'b0, 2'd0, 1'b1, 1'b0, 3'd1, 5'd0},
    '{"R12 ", 3'd1, 1'b0, 32'h0010_0004, 1'b0, 2'd0, 1'b1, 1'b0, 3'd0, 5'd0},
    '{"R3  ", 3'd1, 1'b0, 32'h0050_0000, 1'b0, 2'd0, 1'b1, 1'b0, 3'd2, 5'd0},
    '{"R12 ", 3'd2, 1'b0, 32'h0010_0FFC, 1'b0, 2'd0, 1'b1, 1'b0, 3'd0, 5'd0},
    '{"R4  ", 3'd2, 1'b0, 32'h0020_0000, 1'b0, 2'd0, 1'b1, 1'b0, 3'd3, 5'd0},
    '{"R4  ", 3'd2, 1'b0, 32'h0060_0000, 1'b0, 2'd0, 1'b1, 1'b0, 3'd3, 5'd0},
    '{"R4  ", 3'd1, 1'b0, 32'h0020_0010, 1'b0, 2'd0, 1'b1, 1'b0, 3'd0, 5'd0},
    '{"R5  ", 3'd3, 1'b0, 32'h0030_0000, 1'b0, 2'd0, 1'b1, 1'b0, 3'd4, 5'd0},
    '{"R5  ", 3'd3, 1'b0, 32'h0040_0000, 1'b0, 2'd0, 1'b1, 1'b0, 3'd4, 5'd0},
    '{"R12 ", 3'd3, 1'b0, 32'h0010_0000, 1'b0, 2'd0, 1'b1, 1'b0, 3'd0, 5'd0},
    '{"R6  ", 3'd3, 1'b0, 32'h0010_0000, 1'b0, 2'd1, 1'b1, 1'b0, 3'd4, 5'd0},
    '{"R6  ", 3'd3, 1'b0, 32'h0010_0000, 1'b0, 2'd2, 1'b1, 1'b0, 3'd4, 5'd0},
    '{"R10 ", 3'd3, 1'b0, 32'h0060_0000, 1'b0, 2'd0, 1'b1, 1'b0, 3'd3, 5'd0},
    '{"R7  ", 3'd4, 1'b0, 32'h0010_0000, 1'b1, 2'd0, 1'b1, 1'b0, 3'd5, 5'd5},
    '{"R7  ", 3'd5, 1'b1, 32'h0010_0000, 1'b1, 2'd0, 1'b1, 1'b0, 3'd5, 5'd5},
    '{"R8  ", 3'd5, 1'b0, 32'h0010_0000, 1'b0, 2'd0, 1'b0, 1'b0, 3'd5, 5'd11},
    '{"R10 ", 3'd5, 1'b0, 32'h0060_0000, 1'b1, 2'd0, 1'b0, 1'b0, 3'd5, 5'd5},
    '{"R9  ", 3'd6, 1'b0, 32'h0010_0000, 1'b0, 2'd0, 1'b1, 1'b1, 3'd4, 5'd0},
    '{"R10 ", 3'd6, 1'b1, 32'h0060_0000, 1'b0, 2'd0, 1'b1, 1'b1, 3'd4, 5'd0},
    '{"R9  ", 3'd6, 1'b1, 32'h0010_0000, 1'b0, 2'd0, 1'b1, 1'b0, 3'd0, 5'd0},
    '{"R4  ", 3'd4, 1'b1, 32'h0070_0000, 1'b0, 2'd0, 1'b1, 1'b0, 3'd3, 5'd0},
    '{"R3  ", 3'd7, 1'b0, 32'h0070_0000, 1'b0, 2'd0, 1'b1, 1'b0, 3'd2, 5'd0},
    '{"R9  ", 3'd1, 1'b0, 32'h0010_0000, 1'b0, 2'd0, 1'b1, 1'b1, 3'd0, 5'd0},
    '{"R7  ", 3'd2, 1'b0, 32'h0010_0000, 1'b1, 2'd0, 1'b1, 1'b0, 3'd0, 5'd0},
    '{"R10 ", 3'd3, 1'b0, 32'h0030_0000, 1'b0, 2'd3, 1'b1, 1'b0, 3'd4, 5'd0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqKind = '0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [95:0] itlbImage, dtlbImage;
  logic        segDirect = 1'b0;
  logic [1:0]  cacheLock = '0;
  logic        extEnable = 1'b1;
  logic        littleEndian = 1'b0;
  logic        excValid;
  logic [2:0]  excCause;
  logic [0:31] srr1Bits, dsisrBits;
  logic        setShadowMsr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [23:0] mkEnt(logic v, logic [19:0] tg, logic w, logic i, logic c);
    return {v, tg, w, i, c};
  endfunction

  // R11 image: entry k at bits [24k+23:24k]
  initial begin
    itlbImage = {mkEnt(1'b0, 20'h0, 1'b0, 1'b0, 1'b0), mkEnt(1'b0, 20'h0, 1'b0, 1'b0, 1'b0),
                 mkEnt(1'b0, 20'h00020, 1'b0, 1'b0, 1'b1), mkEnt(1'b1, 20'h00010, 1'b0, 1'b0, 1'b1)};
    dtlbImage = {mkEnt(1'b1, 20'h00400, 1'b0, 1'b1, 1'b1), mkEnt(1'b1, 20'h00300, 1'b1, 1'b0, 1'b1),
                 mkEnt(1'b1, 20'h00200, 1'b0, 1'b0, 1'b0), mkEnt(1'b1, 20'h00100, 1'b0, 1'b0, 1'b1)};
  end

  mmu_exc_classifier u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .itlbImage(itlbImage),
    .dtlbImage(dtlbImage), .segDirect(segDirect), .cacheLock(cacheLock),
    .extEnable(extEnable), .littleEndian(littleEndian), .excValid(excValid),
    .excCause(excCause), .srr1Bits(srr1Bits), .dsisrBits(dsisrBits),
    .setShadowMsr(setShadowMsr)
  );

  task automatic checkOut(string req, logic expValid, logic [2:0] expCause, logic [4:0] dsiBit);
    logic [0:31] eSrr1 = '0;
    logic [0:31] eDsisr = '0;
    logic eMsr;
    if (expCause == 3'd1) eSrr1[13] = 1'b1;
    if (expCause == 3'd2) eSrr1[15] = 1'b1;
    if (dsiBit != 5'd0) eDsisr[dsiBit] = 1'b1;
    eMsr = (expCause == 3'd1) || (expCause == 3'd2) || (expCause == 3'd3);
    total++;
    if (excValid !== expValid || excCause !== expCause || srr1Bits !== eSrr1 ||
        dsisrBits !== eDsisr || setShadowMsr !== eMsr) begin
      bad++;
      $display("FAIL %s: got v=%0b cause=%0d srr1=%h dsisr=%h msr=%0b exp v=%0b cause=%0d srr1=%h dsisr=%h msr=%0b",
               req, excValid, excCause, srr1Bits, dsisrBits, setShadowMsr,
               expValid, expCause, eSrr1, eDsisr, eMsr);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkOut("R1 reset", 1'b0, 3'd0, 5'd0);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1 idle", 1'b0, 3'd0, 5'd0);

    foreach (VEC[n]) begin
      reqValid = 1'b1;
      reqKind = VEC[n].kind; reqWrite = VEC[n].wr; reqAddr = VEC[n].addr;
      segDirect = VEC[n].seg; cacheLock = VEC[n].lock;
      extEnable = VEC[n].extEn; littleEndian = VEC[n].le;
      @(negedge clk);
      checkOut(string'(VEC[n].tag), 1'b1, VEC[n].cause, VEC[n].dsiBit);
    end

    // R1: request dropped -> cleared next cycle
    reqValid = 1'b0; reqKind = 3'd0; reqAddr = 32'h0009_9000;
    @(negedge clk);
    checkOut("R1 drop", 1'b0, 3'd0, 5'd0);
    // R1: a miss then reset in the same cycle clears outputs
    reqValid = 1'b1;
    @(negedge clk);
    checkOut("R1 miss", 1'b1, 3'd1, 5'd0);
    rstN = 1'b0;
    @(negedge clk);
    checkOut("R1 in reset", 1'b0, 3'd0, 5'd0);
    rstN = 1'b1; reqValid = 1'b0;
    @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule